// File: doc/BRIEF.md
# Bus trace trigger sequencer

This block sits beside a system bus and decides which bus cycles a trace buffer should record. Every cycle it checks the address phase (requester, address, read or write) and the data phase (responder, data owner) against a bank of programmable event qualifiers. Each qualifier ANDs the terms it has switched on. It can also require the address to fall inside a base/mask window.

Several trigger sequencers each walk through four ordered stages. A stage either waits for any of a chosen set of events (an OR) or is empty, in which case it is skipped at once. When a sequencer passes its last non-empty stage, it raises an address-sample or a data-sample strobe one cycle later. The address and data of the completing cycle are presented alongside the strobe. This lets a chain start on a request and capture only the data phase that answers it.

The sequencers are split into two groups, and the first group cannot see the highest qualifiers. Three control pulses govern sampling: one starts it, one stops it, and one freezes the trace.

Top module: `bus_trig_seq`

## Requirements
- R1: Qualifier q takes its settings from `qualCfg[q*18 +: 18]`. From the most significant bit down, the settings are: reqEn, reqId[4], rspEn, rspId[4], datEn, datId[4], winEn, cmdRd, cmdWr. The qualifier fires only when every enabled term holds: requester ID equal, responder ID equal, data-owner ID equal, window hit, and command allowed (cmdRd allows reads, cmdWr allows writes, and both clear means any command). The requester, window and command terms also need `busAddrValid`. The responder and data-owner terms also need `busDataValid`. A qualifier with no term enabled never fires.
- R2: The window hits when `(busAddr & winMask) == (winBase & winMask)`.
- R3: Sequencer s, stage k, takes its event mask from `stageCfg[(s*4+k)*5 +: 5]`, with bit q standing for qualifier q. A stage with a zero mask is skipped without waiting, including at the start of the chain. A stage with a nonzero mask is satisfied by any one of the selected events.
- R4: A sequencer advances at most one stage per cycle. An event that completes one stage and would also satisfy the next stage only advances the chain by one.
- R5: When the last non-empty stage is satisfied, the sequencer returns to its first stage. One cycle later it pulses bit s of `hitSeq`, together with `aSample` when `seqKind[s]`=0 or `dSample` when `seqKind[s]`=1.
- R6: With every strobe, `capAddr` and `capData` present `busAddr` and `busData` of the completing cycle. On cycles with no strobe they hold their value.
- R7: Sequencers with an index below 2 never see qualifiers with an index of 4 or more. A stage that selects only such qualifiers never completes for these sequencers.
- R8: `ctlFreeze` stops sampling and takes priority over `ctlStop`, which stops sampling and takes priority over `ctlStart`. While sampling is off, and in any cycle that carries a control pulse, no bus cycle is considered and all sequencers sit at their first stage.
- R9: `frozen` rises one cycle after `ctlFreeze`, and only an effective `ctlStart` clears it.
- R10: An effective `ctlStart` discards any partial progress of every sequencer.
- R11: After reset, sampling is off, `frozen` is low, and all strobes and captured values are zero.
- R12: A sequencer whose four stage masks are all zero never completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlStart | input | 1 | Start-sampling pulse |
| ctlStop | input | 1 | Stop-sampling pulse |
| ctlFreeze | input | 1 | Freeze-trace pulse |
| busAddrValid | input | 1 | Address phase present this cycle |
| busWrite | input | 1 | Address phase is a write (else read) |
| busReqId | input | 4 | Requesting agent ID |
| busAddr | input | 32 | Request address |
| busDataValid | input | 1 | Data phase present this cycle |
| busRspId | input | 4 | Responding agent ID |
| busDataId | input | 4 | Data-owner agent ID |
| busData | input | 32 | Data beat |
| qualCfg | input | 90 | Qualifier settings, 18 bits each |
| winBase | input | 32 | Address window base |
| winMask | input | 32 | Address window mask |
| stageCfg | input | 80 | Stage event masks, 5 bits per stage |
| seqKind | input | 4 | Per-sequencer strobe kind (0 address, 1 data) |
| aSample | output | 1 | Address-sample strobe |
| dSample | output | 1 | Data-sample strobe |
| hitSeq | output | 4 | Sequencers that completed |
| capAddr | output | 32 | Address of the sampled cycle |
| capData | output | 32 | Data of the sampled cycle |
| frozen | output | 1 | Trace frozen |

## Verification
A sequencer left on the wrong stage becomes visible at the ports with the next bus cycle that ought to complete, or ought not to complete, its chain. A strobe then appears or goes missing exactly one cycle later. Stale progress that survives a start or stop is exposed by a data beat sent without its request: a correct block stays silent, and a faulty one raises `dSample` on the following cycle. A wrong run or freeze state shows as strobes during a stopped period, or as a `frozen` level that is wrong one cycle after the pulse.

// File: rtl/trig_pkg.sv
`timescale 1ns/1ps
package trig_pkg;
  parameter int ID_W   = 4;
  parameter int STAGES = 4;

  typedef struct packed {
    logic            reqEn;
    logic [ID_W-1:0] reqId;
    logic            rspEn;
    logic [ID_W-1:0] rspId;
    logic            datEn;
    logic [ID_W-1:0] datId;
    logic            winEn;
    logic            cmdRd;
    logic            cmdWr;
  } qualCfg_t;

  localparam int QCFG_W = $bits(qualCfg_t);

  // control-to-datapath strobes
  typedef struct packed {
    logic active;  // bus cycle is considered
    logic clear;   // discard sequencer progress
  } ctlStb_t;
endpackage

// File: rtl/trig_seq.sv
`timescale 1ns/1ps
module trig_seq
  import trig_pkg::*;
#(
  parameter int NUM_QUAL = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctlStb_t                    ctl,
  input  logic [NUM_QUAL-1:0]        evt,
  input  logic [STAGES*NUM_QUAL-1:0] stageMask,
  output logic                       done
);
  localparam int STG_W = (STAGES > 1) ? $clog2(STAGES) : 1;

  logic [STG_W-1:0]  stg;
  logic [STG_W-1:0]  eff;
  logic              effOk;
  logic              more;
  logic              fire;
  logic [STAGES-1:0] realStg;

  for (genvar k = 0; k < STAGES; k++) begin : g_real
    assign realStg[k] = |stageMask[k*NUM_QUAL +: NUM_QUAL];
  end

  // first non-empty stage at or after the stored pointer, and whether another follows
  always_comb begin
    eff   = '0;
    effOk = 1'b0;
    more  = 1'b0;
    for (int k = STAGES-1; k >= 0; k--) begin
      if (realStg[k] && (k >= int'(stg))) begin
        eff   = STG_W'(k);
        effOk = 1'b1;
      end
    end
    for (int k = 0; k < STAGES; k++) begin
      if (effOk && realStg[k] && (k > int'(eff))) more = 1'b1;
    end
    fire = ctl.active && effOk &&
           (|(stageMask[int'(eff)*NUM_QUAL +: NUM_QUAL] & evt));
    done = fire && !more;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                          stg <= '0;
    else if (ctl.clear || !ctl.active)  stg <= '0;
    else if (fire)                      stg <= more ? (eff + STG_W'(1)) : '0;
  end
endmodule

// File: rtl/trig_ctrl.sv
`timescale 1ns/1ps
module trig_ctrl
  import trig_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    ctlStart,
  input  logic    ctlStop,
  input  logic    ctlFreeze,
  output ctlStb_t stb,
  output logic    frozen
);
  logic running;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      frozen  <= 1'b0;
    end else if (ctlFreeze) begin
      running <= 1'b0;
      frozen  <= 1'b1;
    end else if (ctlStop) begin
      running <= 1'b0;
    end else if (ctlStart) begin
      running <= 1'b1;
      frozen  <= 1'b0;
    end
  end

  always_comb begin
    stb.active = running && !ctlStart && !ctlStop && !ctlFreeze;
    stb.clear  = ctlStart && !ctlStop && !ctlFreeze;
  end
endmodule

// File: rtl/trig_datapath.sv
`timescale 1ns/1ps
module trig_datapath
  import trig_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int NUM_QUAL  = 5,
  parameter int NUM_SEQ   = 4,
  parameter int SEQ_BLK0  = 2,
  parameter int QUAL_BLK0 = 4
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  ctlStb_t                            ctl,
  input  logic                               busAddrValid,
  input  logic                               busWrite,
  input  logic [ID_W-1:0]                    busReqId,
  input  logic [ADDR_W-1:0]                  busAddr,
  input  logic                               busDataValid,
  input  logic [ID_W-1:0]                    busRspId,
  input  logic [ID_W-1:0]                    busDataId,
  input  logic [DATA_W-1:0]                  busData,
  input  logic [NUM_QUAL*QCFG_W-1:0]         qualCfg,
  input  logic [ADDR_W-1:0]                  winBase,
  input  logic [ADDR_W-1:0]                  winMask,
  input  logic [NUM_SEQ*STAGES*NUM_QUAL-1:0] stageCfg,
  input  logic [NUM_SEQ-1:0]                 seqKind,
  output logic                               aSample,
  output logic                               dSample,
  output logic [NUM_SEQ-1:0]                 hitSeq,
  output logic [ADDR_W-1:0]                  capAddr,
  output logic [DATA_W-1:0]                  capData
);
  localparam int SEQ_CFG_W = STAGES * NUM_QUAL;

  logic                winHit;
  logic [NUM_QUAL-1:0] evt;
  logic [NUM_SEQ-1:0]  done;

  assign winHit = ((busAddr ^ winBase) & winMask) == '0;

  for (genvar q = 0; q < NUM_QUAL; q++) begin : g_qual
    qualCfg_t c;
    logic     needA, needD, cmdOk;
    assign c     = qualCfg[q*QCFG_W +: QCFG_W];
    assign needA = c.reqEn | c.winEn | c.cmdRd | c.cmdWr;
    assign needD = c.rspEn | c.datEn;
    assign cmdOk = !(c.cmdRd | c.cmdWr) | (c.cmdRd & !busWrite) | (c.cmdWr & busWrite);
    assign evt[q] = (needA | needD)
                  & (!needA | busAddrValid) & (!needD | busDataValid)
                  & (!c.reqEn | (c.reqId == busReqId))
                  & (!c.winEn | winHit) & cmdOk
                  & (!c.rspEn | (c.rspId == busRspId))
                  & (!c.datEn | (c.datId == busDataId));
  end

  for (genvar s = 0; s < NUM_SEQ; s++) begin : g_seq
    localparam int NVIS = (s < SEQ_BLK0) ? QUAL_BLK0 : NUM_QUAL;
    logic [NUM_QUAL-1:0] visMask;
    for (genvar q = 0; q < NUM_QUAL; q++) begin : g_vis
      assign visMask[q] = (q < NVIS);
    end
    trig_seq #(.NUM_QUAL(NUM_QUAL)) u_seq (
      .clk       (clk),
      .rstN      (rstN),
      .ctl       (ctl),
      .evt       (evt & visMask),
      .stageMask (stageCfg[s*SEQ_CFG_W +: SEQ_CFG_W]),
      .done      (done[s])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aSample <= 1'b0;
      dSample <= 1'b0;
      hitSeq  <= '0;
      capAddr <= '0;
      capData <= '0;
    end else begin
      aSample <= |(done & ~seqKind);
      dSample <= |(done & seqKind);
      hitSeq  <= done;
      if (|done) begin
        capAddr <= busAddr;
        capData <= busData;
      end
    end
  end
endmodule

// File: rtl/bus_trig_seq.sv
`timescale 1ns/1ps
module bus_trig_seq
  import trig_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int NUM_QUAL  = 5,
  parameter int NUM_SEQ   = 4,
  parameter int SEQ_BLK0  = 2,
  parameter int QUAL_BLK0 = 4
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               ctlStart,
  input  logic                               ctlStop,
  input  logic                               ctlFreeze,
  input  logic                               busAddrValid,
  input  logic                               busWrite,
  input  logic [ID_W-1:0]                    busReqId,
  input  logic [ADDR_W-1:0]                  busAddr,
  input  logic                               busDataValid,
  input  logic [ID_W-1:0]                    busRspId,
  input  logic [ID_W-1:0]                    busDataId,
  input  logic [DATA_W-1:0]                  busData,
  input  logic [NUM_QUAL*QCFG_W-1:0]         qualCfg,
  input  logic [ADDR_W-1:0]                  winBase,
  input  logic [ADDR_W-1:0]                  winMask,
  input  logic [NUM_SEQ*STAGES*NUM_QUAL-1:0] stageCfg,
  input  logic [NUM_SEQ-1:0]                 seqKind,
  output logic                               aSample,
  output logic                               dSample,
  output logic [NUM_SEQ-1:0]                 hitSeq,
  output logic [ADDR_W-1:0]                  capAddr,
  output logic [DATA_W-1:0]                  capData,
  output logic                               frozen
);
  ctlStb_t ctlStb;

  trig_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ctlStart(ctlStart), .ctlStop(ctlStop),
    .ctlFreeze(ctlFreeze), .stb(ctlStb), .frozen(frozen)
  );

  trig_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_QUAL(NUM_QUAL),
    .NUM_SEQ(NUM_SEQ), .SEQ_BLK0(SEQ_BLK0), .QUAL_BLK0(QUAL_BLK0)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctlStb),
    .busAddrValid(busAddrValid), .busWrite(busWrite), .busReqId(busReqId),
    .busAddr(busAddr), .busDataValid(busDataValid), .busRspId(busRspId),
    .busDataId(busDataId), .busData(busData),
    .qualCfg(qualCfg), .winBase(winBase), .winMask(winMask),
    .stageCfg(stageCfg), .seqKind(seqKind),
    .aSample(aSample), .dSample(dSample), .hitSeq(hitSeq),
    .capAddr(capAddr), .capData(capData)
  );
endmodule

// File: rtl/trig_checker.sv
`timescale 1ns/1ps
module trig_checker #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int NUM_SEQ = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               ctlStart,
  input logic               ctlStop,
  input logic               ctlFreeze,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [DATA_W-1:0]  busData,
  input logic               aSample,
  input logic               dSample,
  input logic [NUM_SEQ-1:0] hitSeq,
  input logic [ADDR_W-1:0]  capAddr,
  input logic [DATA_W-1:0]  capData,
  input logic               frozen
);
  a_r8_stop_silent: assert property (@(posedge clk) disable iff (!rstN)
    ctlStop |=> !(aSample || dSample));
  a_r8_freeze_silent: assert property (@(posedge clk) disable iff (!rstN)
    ctlFreeze |=> !(aSample || dSample));
  a_r8_start_silent: assert property (@(posedge clk) disable iff (!rstN)
    ctlStart |=> !(aSample || dSample));
  a_r9_freeze_sets: assert property (@(posedge clk) disable iff (!rstN)
    ctlFreeze |=> frozen);
  a_r9_freeze_holds: assert property (@(posedge clk) disable iff (!rstN)
    (frozen && !ctlStart) |=> frozen);
  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    (ctlStart && !ctlStop && !ctlFreeze) |=> !frozen);
  a_r5_strobe_has_seq: assert property (@(posedge clk) disable iff (!rstN)
    (aSample || dSample) |-> (hitSeq != '0));
  a_r5_seq_has_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (hitSeq != '0) |-> (aSample || dSample));
  a_r6_addr_of_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (aSample || dSample) |-> (capAddr == $past(busAddr)));
  a_r6_data_of_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (aSample || dSample) |-> (capData == $past(busData)));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(aSample || dSample) |-> ($stable(capAddr) && $stable(capData)));
endmodule

bind bus_trig_seq trig_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SEQ(NUM_SEQ)
) u_chk (
  .clk(clk), .rstN(rstN), .ctlStart(ctlStart), .ctlStop(ctlStop),
  .ctlFreeze(ctlFreeze), .busAddr(busAddr), .busData(busData),
  .aSample(aSample), .dSample(dSample), .hitSeq(hitSeq),
  .capAddr(capAddr), .capData(capData), .frozen(frozen)
);

// File: tb/bus_trig_seq_tb.sv
`timescale 1ns/1ps
module bus_trig_seq_tb;
  import trig_pkg::*;

  localparam int NQ = 5;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctlStart = 0, ctlStop = 0, ctlFreeze = 0;
  logic busAddrValid = 0, busWrite = 0, busDataValid = 0;
  logic [3:0]  busReqId = 0, busRspId = 0, busDataId = 0;
  logic [31:0] busAddr = 0, busData = 0;
  logic [NQ*QCFG_W-1:0]   qualCfg = '0;
  logic [31:0]            winBase = 32'h4000_0000, winMask = 32'hF000_0000;
  logic [NS*STAGES*NQ-1:0] stageCfg = '0;
  logic [NS-1:0]          seqKind = '0;
  logic        aSample, dSample, frozen;
  logic [3:0]  hitSeq;
  logic [31:0] capAddr, capData;

  int nChecks = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  bus_trig_seq u_dut (
    .clk(clk), .rstN(rstN), .ctlStart(ctlStart), .ctlStop(ctlStop), .ctlFreeze(ctlFreeze),
    .busAddrValid(busAddrValid), .busWrite(busWrite), .busReqId(busReqId), .busAddr(busAddr),
    .busDataValid(busDataValid), .busRspId(busRspId), .busDataId(busDataId), .busData(busData),
    .qualCfg(qualCfg), .winBase(winBase), .winMask(winMask), .stageCfg(stageCfg),
    .seqKind(seqKind), .aSample(aSample), .dSample(dSample), .hitSeq(hitSeq),
    .capAddr(capAddr), .capData(capData), .frozen(frozen)
  );

  typedef struct {
    logic        a, d, frz, ck;
    logic [3:0]  hit;
    logic [31:0] ad, dt;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic qualCfg_t mkQ(input logic re, input logic [3:0] ri, input logic se,
      input logic [3:0] si, input logic de, input logic [3:0] di, input logic we,
      input logic rd, input logic wr);
    qualCfg_t c;
    c.reqEn = re; c.reqId = ri; c.rspEn = se; c.rspId = si;
    c.datEn = de; c.datId = di; c.winEn = we; c.cmdRd = rd; c.cmdWr = wr;
    return c;
  endfunction

  task automatic setStage(input int s, input int k, input logic [NQ-1:0] m);
    stageCfg[(s*STAGES+k)*NQ +: NQ] = m;
  endtask

  // driver: one bus cycle plus the result it must produce one cycle later
  task automatic step(input logic av, input logic wr, input logic [3:0] rq, input logic [31:0] ad,
      input logic dv, input logic [3:0] rs, input logic [3:0] di, input logic [31:0] dt,
      input logic st, input logic sp, input logic fz,
      input logic ea, input logic ed, input logic [3:0] eh, input logic ef,
      input logic ck, input logic [31:0] ead, input logic [31:0] edt, input string tag);
    exp_t e;
    @(negedge clk);
    busAddrValid = av; busWrite = wr; busReqId = rq; busAddr = ad;
    busDataValid = dv; busRspId = rs; busDataId = di; busData = dt;
    ctlStart = st; ctlStop = sp; ctlFreeze = fz;
    e.a = ea; e.d = ed; e.hit = eh; e.frz = ef; e.ck = ck; e.ad = ead; e.dt = edt; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic ctl(input logic st, input logic sp, input logic fz, input logic ef, input string tag);
    step(0,0,0,0, 0,0,0,0, st,sp,fz, 0,0,4'b0000,ef, 0,0,0, tag);
  endtask

  task automatic addrCyc(input logic wr, input logic [3:0] rq, input logic [31:0] ad,
      input logic ea, input logic ed, input logic [3:0] eh, input logic ef, input string tag);
    step(1,wr,rq,ad, 0,0,0,0, 0,0,0, ea,ed,eh,ef, eh != 0, ad, 32'h0, tag);
  endtask

  task automatic dataCyc(input logic [3:0] rs, input logic [3:0] di, input logic [31:0] dt,
      input logic ea, input logic ed, input logic [3:0] eh, input logic ef, input string tag);
    step(0,0,0,0, 1,rs,di,dt, 0,0,0, ea,ed,eh,ef, eh != 0, 32'h0, dt, tag);
  endtask

  // monitor: compares registered outputs just after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        chk({aSample,dSample,hitSeq,frozen} === {e.a,e.d,e.hit,e.frz}, {e.tag, " strobes"},
            {57'b0,aSample,dSample,hitSeq,frozen}, {57'b0,e.a,e.d,e.hit,e.frz});
        if (e.ck)
          chk({capAddr,capData} === {e.ad,e.dt}, {e.tag, " capture"},
              {capAddr,capData}, {e.ad,e.dt});
      end
    end
  end

  initial begin
    #(4 * 150000);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    // configuration A
    qualCfg[0*QCFG_W +: QCFG_W] = mkQ(1,4'd1, 0,0, 0,0, 1, 1,1); // cpu, window, rd|wr
    qualCfg[1*QCFG_W +: QCFG_W] = mkQ(1,4'd2, 0,0, 0,0, 0, 0,1); // bridge writes
    qualCfg[2*QCFG_W +: QCFG_W] = mkQ(0,0, 1,4'd1, 1,4'd1, 0, 0,0);
    qualCfg[3*QCFG_W +: QCFG_W] = mkQ(0,0, 1,4'd2, 1,4'd1, 0, 0,0);
    qualCfg[4*QCFG_W +: QCFG_W] = mkQ(0,0, 0,0, 1,4'd2, 0, 0,0);
    setStage(0,0,5'b00001);
    setStage(1,0,5'b00001); setStage(1,1,5'b01100);
    setStage(2,0,5'b00010);
    setStage(3,0,5'b10000);
    seqKind = 4'b1010;

    repeat (3) @(posedge clk);
    #1;
    chk({aSample,dSample,hitSeq,frozen,capAddr,capData} === '0, "R11 reset state",
        {57'b0,aSample,dSample,hitSeq,frozen}, 64'h0);
    @(negedge clk);
    rstN = 1'b1;

    ctl(1,0,0,0, "R8 start pulse silent");
    addrCyc(1,4'd1,32'h4000_0010, 1,0,4'b0001,0, "R1 R5 cpu write addr sample");
    dataCyc(4'd1,4'd1,32'hDEAD_BEEF, 0,1,4'b0010,0, "R3 R6 write data after request");
    step(0,0,0,0, 1,4'd1,4'd1,32'h1111_1111, 0,0,0, 0,0,4'b0000,0, 1,32'h0,32'hDEAD_BEEF,
         "R6 orphan data ignored, capture held");
    addrCyc(0,4'd1,32'h5000_0000, 0,0,4'b0000,0, "R2 outside window");
    addrCyc(0,4'd1,32'h4FFF_FFFC, 1,0,4'b0001,0, "R2 window top edge");
    dataCyc(4'd2,4'd1,32'h1234_5678, 0,1,4'b0010,0, "R3 read return via OR");
    addrCyc(1,4'd2,32'h0000_1000, 1,0,4'b0100,0, "R1 bridge write");
    addrCyc(0,4'd2,32'h0000_2000, 0,0,4'b0000,0, "R1 command filter");
    dataCyc(4'd0,4'd2,32'hCAFE_0001, 0,1,4'b1000,0, "R1 data owner only");
    step(0,1,4'd1,32'h4000_0020, 0,0,0,0, 0,0,0, 0,0,4'b0000,0, 0,0,0, "R1 needs address valid");
    step(1,0,4'd1,32'h4000_0040, 1,4'd0,4'd2,32'hABCD_0002, 0,0,0, 1,1,4'b1001,0,
         1,32'h4000_0040,32'hABCD_0002, "R5 two sequencers one cycle");
    dataCyc(4'd1,4'd1,32'h0BAD_F00D, 0,1,4'b0010,0, "R5 chain from combined cycle");

    step(1,1,4'd1,32'h4000_0000, 0,0,0,0, 0,1,0, 0,0,4'b0000,0, 0,0,0, "R8 stop cycle ignored");
    addrCyc(1,4'd1,32'h4000_0000, 0,0,4'b0000,0, "R8 stopped");
    ctl(1,0,0,0, "R8 restart");
    addrCyc(1,4'd1,32'h4000_0100, 1,0,4'b0001,0, "R10 arm chain");
    ctl(1,0,0,0, "R10 start while running");
    dataCyc(4'd1,4'd1,32'h7777_0000, 0,0,4'b0000,0, "R10 progress discarded");
    ctl(0,0,1,1, "R9 freeze");
    addrCyc(1,4'd1,32'h4000_0000, 0,0,4'b0000,1, "R8 frozen silent");
    ctl(0,1,0,1, "R9 stop keeps frozen");
    ctl(1,1,0,1, "R8 stop beats start");
    addrCyc(1,4'd1,32'h4000_0000, 0,0,4'b0000,1, "R8 still stopped");
    ctl(1,0,0,0, "R9 start clears frozen");
    addrCyc(1,4'd1,32'h4000_0200, 1,0,4'b0001,0, "R8 running again");
    ctl(0,1,0,0, "R8 stop");

    // configuration B, applied while stopped
    @(negedge clk);
    stageCfg = '0;
    setStage(0,0,5'b10000);
    setStage(1,0,5'b00001); setStage(1,2,5'b00001);
    setStage(3,1,5'b10000);
    seqKind = 4'b1010;
    ctl(1,0,0,0, "R8 start B");
    dataCyc(4'd0,4'd2,32'h55AA_55AA, 0,1,4'b1000,0, "R7 R3 block0 blind, leading skip");
    addrCyc(1,4'd1,32'h4000_0200, 0,0,4'b0000,0, "R4 one stage per cycle");
    addrCyc(1,4'd2,32'h0000_1000, 0,0,4'b0000,0, "R12 empty sequencer");
    addrCyc(1,4'd1,32'h4000_0300, 0,1,4'b0010,0, "R4 second match completes");
    addrCyc(1,4'd1,32'h4000_0400, 0,0,4'b0000,0, "R5 back to first stage");
    addrCyc(0,4'd1,32'h4000_0500, 0,1,4'b0010,0, "R5 repeat chain");

    ctl(0,0,0,0, "R8 idle");
    repeat (3) @(posedge clk);
    #2;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule